// File: doc/BRIEF.md
# Selector-to-Descriptor Address Translator

This block turns a 16-bit protected-mode selector into the 24-bit physical address of the 8-byte descriptor it names. Bit 2 of the selector picks one of two descriptor tables, a global one or a local one; the upper thirteen bits index an entry inside that table. Each table has a physical base register and a byte-limit register, both loaded through a small configuration write port. A lookup that would touch bytes past the chosen table's limit is flagged with general-protection fault number 13, which the caller can treat as restartable.

The lookup can also check a descriptor type. The caller tells the block whether the fetched descriptor is a memory segment descriptor or a system descriptor and gives its 3-bit system type. The block then reports fault 13 if that kind may not live in the selected table. Every lookup takes one clock: a request accepted on one edge has its address, fault flag, fault number and requested privilege level on the registered outputs after that edge. Memory access and privilege comparison are left to neighbouring logic.

Top module: `seltab_xlate`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rsp_valid` and `rsp_fault` are 0. Both table bases and both limits reset to 0.
- R2: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high. All other response fields are only meaningful while `rsp_valid` is high.
- R3: Selector bit 2 chooses the table: 0 selects the global table and 1 selects the local table.
- R4: `rsp_addr` equals the selected table's base plus the entry index (selector bits 15..3) times 8, modulo 2^24.
- R5: If index*8+7 is greater than the selected table's limit, `rsp_fault` is 1. Whenever `rsp_fault` is 1, `rsp_fault_no` is 13; otherwise it is 0.
- R6: `rsp_rpl` equals selector bits 1..0 of the request.
- R7: With `req_chk` high, a global-table lookup faults (13) for a system descriptor (`req_dseg`=0) of type 6 (interrupt gate) or 7 (trap gate). Every other kind is allowed.
- R8: With `req_chk` high, a local-table lookup faults (13) unless the descriptor is a segment descriptor (`req_dseg`=1) or a system descriptor of type 4 (call gate) or 5 (task gate).
- R9: A configuration write (`cfg_tbl` 0 = global, 1 = local) loads that table's base and limit on the clock edge. A lookup in the same cycle still sees the old values, and lookups in later cycles see the new ones.
- R10: With `req_chk` low, the type inputs have no effect and only the limit can raise a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write enable for a table's base and limit |
| cfg_tbl | input | 1 | Table written: 0 global, 1 local |
| cfg_base | input | 24 | New physical base |
| cfg_limit | input | 16 | New byte limit |
| req_valid | input | 1 | Lookup request |
| req_sel | input | 16 | Selector to translate |
| req_chk | input | 1 | Enable descriptor-type check |
| req_dseg | input | 1 | 1 = memory segment descriptor, 0 = system descriptor |
| req_dtype | input | 3 | System descriptor type (4 call gate, 5 task gate, 6 interrupt gate, 7 trap gate) |
| rsp_valid | output | 1 | Response present |
| rsp_addr | output | 24 | Physical address of the descriptor |
| rsp_fault | output | 1 | Lookup faulted |
| rsp_fault_no | output | 8 | 13 when faulted, else 0 |
| rsp_rpl | output | 2 | Requested privilege level from the selector |

## Verification
The bench probes the exact limit boundary, where index*8+7 equals the limit or exceeds it by one. A comparison off by the seven trailing bytes would pass the last legal entry or fail it. It places a local table just below the top of the address space, so a design that does not wrap modulo 2^24 returns a wrong or widened address. It checks each gate type against each table, so a swapped rule set shows up as faults on call gates or missed faults on interrupt gates in the wrong table. It also issues a table write and a lookup in the same cycle, so a design that forwards the new base early returns the new address one lookup too soon.

// File: rtl/seltab_pkg.sv
package seltab_pkg;
  typedef enum logic {TBL_GLOBAL = 1'b0, TBL_LOCAL = 1'b1} tbl_e;

  localparam logic [2:0] SYS_CALL_GATE = 3'd4;
  localparam logic [2:0] SYS_TASK_GATE = 3'd5;
  localparam logic [2:0] SYS_INTR_GATE = 3'd6;
  localparam logic [2:0] SYS_TRAP_GATE = 3'd7;

  localparam logic [7:0] FAULT_GP = 8'd13;
endpackage

// File: rtl/seltab_regs.sv
module seltab_regs #(
  parameter int ADDR_W = 24,
  parameter int LIM_W  = 16,
  parameter int NTBL   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_idx,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [LIM_W-1:0]  wr_limit,
  input  logic              rd_idx,
  output logic [ADDR_W-1:0] rd_base,
  output logic [LIM_W-1:0]  rd_limit
);
  logic [ADDR_W-1:0] base_q  [NTBL];
  logic [LIM_W-1:0]  limit_q [NTBL];

  for (genvar t = 0; t < NTBL; t++) begin : g_tbl
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[t]  <= '0;
        limit_q[t] <= '0;
      end else if (wr_en && (int'(wr_idx) == t)) begin
        base_q[t]  <= wr_base;
        limit_q[t] <= wr_limit;
      end
    end
  end

  assign rd_base  = base_q[rd_idx];
  assign rd_limit = limit_q[rd_idx];
endmodule

// File: rtl/seltab_addr.sv
module seltab_addr #(
  parameter int ADDR_W = 24,
  parameter int LIM_W  = 16,
  parameter int SEL_W  = 16,
  parameter int ESHIFT = 3
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] base,
  input  logic [LIM_W-1:0]  limit,
  output logic [ADDR_W-1:0] addr,
  output logic              over
);
  localparam int IDX_W = SEL_W - ESHIFT;
  localparam int CW    = ((SEL_W > LIM_W) ? SEL_W : LIM_W) + 1;

  logic [IDX_W-1:0] index;
  logic [SEL_W-1:0] offs;
  logic [CW-1:0]    last;

  assign index = sel[SEL_W-1:ESHIFT];
  assign offs  = {index, {ESHIFT{1'b0}}};
  assign last  = CW'(offs) + CW'((1 << ESHIFT) - 1);
  assign over  = last > CW'(limit);
  assign addr  = base + ADDR_W'(offs);
endmodule

// File: rtl/seltab_typechk.sv
module seltab_typechk
  import seltab_pkg::*;
(
  input  logic       tbl,
  input  logic       dseg,
  input  logic [2:0] dtype,
  output logic       bad
);
  always_comb begin
    if (dseg) begin
      bad = 1'b0;
    end else if (tbl == TBL_GLOBAL) begin
      bad = (dtype == SYS_INTR_GATE) || (dtype == SYS_TRAP_GATE);
    end else begin
      bad = !((dtype == SYS_CALL_GATE) || (dtype == SYS_TASK_GATE));
    end
  end
endmodule

// File: rtl/seltab_xlate.sv
module seltab_xlate
  import seltab_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LIM_W  = 16,
  parameter int SEL_W  = 16,
  parameter int TI_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_tbl,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [LIM_W-1:0]  cfg_limit,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic              req_chk,
  input  logic              req_dseg,
  input  logic [2:0]        req_dtype,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_fault,
  output logic [7:0]        rsp_fault_no,
  output logic [1:0]        rsp_rpl
);
  localparam int ESHIFT = TI_BIT + 1;

  logic              tbl;
  logic [ADDR_W-1:0] base;
  logic [LIM_W-1:0]  limit;
  logic [ADDR_W-1:0] addr_c;
  logic              over_c;
  logic              type_bad;
  logic              fault_c;

  assign tbl = req_sel[TI_BIT];

  seltab_regs #(.ADDR_W(ADDR_W), .LIM_W(LIM_W), .NTBL(2)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_tbl),
    .wr_base  (cfg_base),
    .wr_limit (cfg_limit),
    .rd_idx   (tbl),
    .rd_base  (base),
    .rd_limit (limit)
  );

  seltab_addr #(.ADDR_W(ADDR_W), .LIM_W(LIM_W), .SEL_W(SEL_W), .ESHIFT(ESHIFT)) u_addr (
    .sel   (req_sel),
    .base  (base),
    .limit (limit),
    .addr  (addr_c),
    .over  (over_c)
  );

  seltab_typechk u_type (
    .tbl   (tbl),
    .dseg  (req_dseg),
    .dtype (req_dtype),
    .bad   (type_bad)
  );

  assign fault_c = over_c || (req_chk && type_bad);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_fault_no <= '0;
      rsp_addr     <= '0;
      rsp_rpl      <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && fault_c;
      if (req_valid) begin
        rsp_addr     <= addr_c;
        rsp_rpl      <= req_sel[1:0];
        rsp_fault_no <= fault_c ? FAULT_GP : 8'd0;
      end
    end
  end
endmodule

// File: rtl/seltab_xlate_chk.sv
module seltab_xlate_chk #(
  parameter int ADDR_W = 24,
  parameter int SEL_W  = 16,
  parameter int TI_BIT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [SEL_W-1:0]  req_sel,
  input logic              req_chk,
  input logic              req_dseg,
  input logic [2:0]        req_dtype,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              rsp_fault,
  input logic [7:0]        rsp_fault_no,
  input logic [1:0]        rsp_rpl
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!rsp_valid && !rsp_fault)); // R1

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2

  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R2

  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_fault ? (rsp_fault_no == 8'd13) : (rsp_fault_no == 8'd0))); // R5

  AST_FAULT_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !rsp_fault); // R5

  AST_RPL_PASS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_rpl == $past(req_sel[1:0]))); // R6

  AST_LOCAL_INTR_TRAP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_sel[TI_BIT] && req_chk && !req_dseg && req_dtype[2] && req_dtype[1])
    |=> rsp_fault); // R8

  AST_GLOBAL_INTR_TRAP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_sel[TI_BIT] && req_chk && !req_dseg && req_dtype[2] && req_dtype[1])
    |=> rsp_fault); // R7
endmodule

bind seltab_xlate seltab_xlate_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .TI_BIT(TI_BIT)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_sel      (req_sel),
  .req_chk      (req_chk),
  .req_dseg     (req_dseg),
  .req_dtype    (req_dtype),
  .rsp_valid    (rsp_valid),
  .rsp_addr     (rsp_addr),
  .rsp_fault    (rsp_fault),
  .rsp_fault_no (rsp_fault_no),
  .rsp_rpl      (rsp_rpl)
);

// File: tb/test_seltab_xlate.sv
`timescale 1ns/1ps
module test_seltab_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_tbl = 1'b0;
  logic [23:0] cfg_base = '0;
  logic [15:0] cfg_limit = '0;
  logic        req_valid = 1'b0;
  logic [15:0] req_sel = '0;
  logic        req_chk = 1'b0;
  logic        req_dseg = 1'b0;
  logic [2:0]  req_dtype = '0;
  logic        rsp_valid;
  logic [23:0] rsp_addr;
  logic        rsp_fault;
  logic [7:0]  rsp_fault_no;
  logic [1:0]  rsp_rpl;

  always #10 clk = ~clk;

  seltab_xlate i_seltab_xlate (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl), .cfg_base(cfg_base),
    .cfg_limit(cfg_limit), .req_valid(req_valid), .req_sel(req_sel), .req_chk(req_chk),
    .req_dseg(req_dseg), .req_dtype(req_dtype), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_fault(rsp_fault), .rsp_fault_no(rsp_fault_no), .rsp_rpl(rsp_rpl)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // behavioural model state
  int m_base[2];
  int m_lim[2];
  bit e_valid;
  int e_addr;
  bit e_fault;
  int e_rpl;
  string e_tag_a;
  string e_tag_f;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    check(rsp_valid == e_valid, "R2 valid", int'(rsp_valid), int'(e_valid));
    if (e_valid) begin
      check(int'(rsp_addr) == e_addr, e_tag_a, int'(rsp_addr), e_addr);
      check(rsp_fault == e_fault, e_tag_f, int'(rsp_fault), int'(e_fault));
      check(int'(rsp_fault_no) == (e_fault ? 13 : 0), "R5 fault number",
            int'(rsp_fault_no), e_fault ? 13 : 0);
      check(int'(rsp_rpl) == e_rpl, "R6 rpl", int'(rsp_rpl), e_rpl);
    end else begin
      check(rsp_fault == 1'b0, "R5 fault without valid", int'(rsp_fault), 0);
    end
  endtask

  // one clock: check last response, drive new inputs, predict the next response
  task automatic step(input bit we, input bit wt, input int wb, input int wl,
                      input bit v, input int sel, input bit chk, input bit dseg,
                      input int dtype, input string atag);
    int t;
    int idx;
    bit lim_f;
    bit typ_f;
    @(negedge clk);
    compare();
    cfg_we = we; cfg_tbl = wt; cfg_base = 24'(wb); cfg_limit = 16'(wl);
    req_valid = v; req_sel = 16'(sel); req_chk = chk; req_dseg = dseg; req_dtype = 3'(dtype);
    t = (sel >> 2) & 1;
    idx = (sel >> 3) & 16'h1FFF;
    e_valid = v;
    e_addr = (m_base[t] + idx * 8) & 24'hFFFFFF;
    lim_f = (idx * 8 + 7) > m_lim[t];
    if (!chk) typ_f = 1'b0;
    else if (dseg) typ_f = 1'b0;
    else if (t == 0) typ_f = (dtype == 6) || (dtype == 7);
    else typ_f = !((dtype == 4) || (dtype == 5));
    e_fault = lim_f || typ_f;
    e_rpl = sel & 3;
    e_tag_a = atag;
    if (lim_f) e_tag_f = "R5 limit fault";
    else if (!chk) e_tag_f = "R10 no type check";
    else if (t == 0) e_tag_f = "R7 global type rule";
    else e_tag_f = "R8 local type rule";
    if (we) begin
      m_base[wt] = wb & 24'hFFFFFF;
      m_lim[wt] = wl & 16'hFFFF;
    end
  endtask

  task automatic look(input int sel, input bit chk, input bit dseg, input int dtype, input string atag);
    step(1'b0, 1'b0, 0, 0, 1'b1, sel, chk, dseg, dtype, atag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_base[0] = 0; m_base[1] = 0; m_lim[0] = 0; m_lim[1] = 0;
    e_valid = 1'b0; e_addr = 0; e_fault = 1'b0; e_rpl = 0;
    e_tag_a = "R4 addr"; e_tag_f = "R5 fault";
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 reset valid", int'(rsp_valid), 0);
    check(rsp_fault == 1'b0, "R1 reset fault", int'(rsp_fault), 0);
    rst = 1'b0;
    // reset limits are 0: entry 0 ends at byte 7 > 0
    look(16'h0000, 1'b0, 1'b0, 0, "R1 reset base");
    // configure: global base 0x001000 limit 0xFF; local base near top, limit 0x3F
    step(1'b1, 1'b0, 24'h001000, 16'h00FF, 1'b0, 0, 1'b0, 1'b0, 0, "R9");
    step(1'b1, 1'b1, 24'hFFFFF0, 16'h003F, 1'b0, 0, 1'b0, 1'b0, 0, "R9");
    look((31 << 3) | 1, 1'b0, 1'b0, 0, "R3 R4 global last legal");
    look((32 << 3) | 2, 1'b0, 1'b0, 0, "R5 global one past");
    look((3 << 3) | 4 | 3, 1'b0, 1'b0, 0, "R3 R4 local wrap");
    look((7 << 3) | 4, 1'b0, 1'b0, 0, "R4 local last legal");
    look((8 << 3) | 4, 1'b0, 1'b0, 0, "R5 local one past");
    // type rules
    for (int ty = 0; ty < 8; ty++) begin
      look((1 << 3), 1'b1, 1'b0, ty, "R7 global types");
      look((1 << 3) | 4, 1'b1, 1'b0, ty, "R8 local types");
    end
    look((2 << 3), 1'b1, 1'b1, 7, "R7 global segment");
    look((2 << 3) | 4, 1'b1, 1'b1, 1, "R8 local segment");
    look((2 << 3) | 4, 1'b0, 1'b0, 7, "R10 local trap unchecked");
    look((2 << 3), 1'b0, 1'b0, 6, "R10 global intr unchecked");
    // same-cycle write and lookup sees old base
    step(1'b1, 1'b0, 24'h200000, 16'hFFFF, 1'b1, (5 << 3), 1'b0, 1'b0, 0, "R9 old base");
    look((5 << 3), 1'b0, 1'b0, 0, "R9 new base");
    look(16'hFFF8, 1'b0, 1'b0, 0, "R5 max index at full limit");
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 15);
      step(r == 0, 1'($urandom_range(0, 1)), int'($urandom),
           (r == 1) ? 16'hFFFF : int'($urandom_range(0, 1023)),
           r > 3, int'($urandom_range(0, 65535)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), int'($urandom_range(0, 7)), "R3 R4 random");
    end
    step(1'b0, 1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b0, 0, "R2");
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule